// File: doc/BRIEF.md
# Express Channel Drop Tap

One tap sits at each node along a one-way express channel. A source drives the channel, and the channel runs past between one and k−1 downstream nodes in the same row or column. The tap watches the flits that go by. When a head flit arrives, the tap reads the destination node field from the flit payload and compares it with the address of the local node. It makes one steering choice for the whole packet. A packet for this node goes into the local router input, and the downstream part of the channel stays quiet. A packet for any other node is repeated to the next tap without change.

A broadcast bit in the head flit makes every tap both keep a copy and pass the packet on. A full two-dimensional broadcast therefore takes two network hops: the packet crosses the first dimension, then each receiving node sends it along the second dimension.

The tap at the far end of a channel has nowhere to forward a packet. It treats a packet that is neither for this node nor a broadcast as misrouted, discards it, and raises an error pulse. The repeat path and the local delivery path each add one registered cycle. While an output carries no flit, its data and flag registers keep their previous values, so the wires beyond the tap do not toggle.

Top module: `mdx_drop_tap`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `dn_vld`, `loc_vld` and `misroute_err` are low, and every data and flag output is zero.
- R2: In a head flit, bits [ADDR_W-1:0] of `up_data` hold the destination node, and bit ADDR_W holds the broadcast bit. If the broadcast bit is 0 and the destination equals `tap_addr`, the flit appears on the `loc_*` outputs one cycle later, and `dn_vld` stays low.
- R3: On a tap that is not the last one, a head flit with broadcast bit 0 and a destination different from `tap_addr` appears one cycle later on the `dn_*` outputs with identical data, head flag and tail flag, and `loc_vld` stays low.
- R4: Body and tail flits follow the choice made at their packet's head, whatever their own payload bits contain.
- R5: A head flit with broadcast bit 1 sends every flit of its packet to both outputs on a tap that is not the last one. On the last tap, the packet goes to the local output only.
- R6: The choice is cleared after a flit with the tail flag set. A flit that is both head and tail decides and clears in the same cycle. A non-head flit that arrives with no packet open is discarded on both outputs.
- R7: When `dn_vld` is low, `dn_data`, `dn_head` and `dn_tail` keep their previous values. When `loc_vld` is low, the `loc_*` data and flags keep theirs.
- R8: On the last tap, a packet that is neither addressed to `tap_addr` nor a broadcast is sent to neither output. `misroute_err` pulses high for one cycle, one cycle after that packet's head flit.
- R9: Cycles with `up_vld` low in the middle of a packet produce no output flit and do not change the packet's steering choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_addr | input | ADDR_W | Node address of this tap (ADDR_W = clog2(NODE_CNT)) |
| up_vld | input | 1 | Upstream flit valid |
| up_head | input | 1 | Upstream flit is a packet head |
| up_tail | input | 1 | Upstream flit is a packet tail |
| up_data | input | DATA_W | Upstream flit payload |
| dn_vld | output | 1 | Downstream repeated flit valid |
| dn_head | output | 1 | Downstream head flag |
| dn_tail | output | 1 | Downstream tail flag |
| dn_data | output | DATA_W | Downstream payload |
| loc_vld | output | 1 | Local delivery flit valid |
| loc_head | output | 1 | Local head flag |
| loc_tail | output | 1 | Local tail flag |
| loc_data | output | DATA_W | Local payload |
| misroute_err | output | 1 | One-cycle pulse for a misrouted packet at the last tap |

## Verification
The bench drives a middle tap and a last tap with the same flit stream and targets several corner cases:
- **Body-flit payloads that look like addresses.** Some body flits carry low bits equal to the tap address, and some carry a set broadcast bit. A design that decodes every flit instead of only the head would split such a packet between the two outputs.
- **Single-flit packets sent back to back, and a stray body flit after a tail.** A design that fails to clear its choice at the tail would steer a later packet, or the stray flit, by a stale decision.
- **Bubbles in the middle of a packet.** These expose a design that emits a phantom flit or loses its state during a gap.
- **Hold behaviour of both outputs.** The data outputs are compared on every cycle, not only when valid is high. A repeater that reloads its registers while idle therefore shows up as a mismatch.
- **The last tap.** This catches a design that forwards a misrouted packet past the end of the channel, or that raises the error for broadcasts.

// File: rtl/mdx_tap_pkg.sv
package mdx_tap_pkg;

  // Per-packet steering choice held by a tap.
  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,  // no packet open, flit discarded
    RT_LOCAL = 3'd1,  // deliver to this node only
    RT_PASS  = 3'd2,  // repeat downstream only
    RT_BOTH  = 3'd3,  // broadcast: deliver and repeat
    RT_DROP  = 3'd4   // misrouted at channel end
  } route_e;

  // Decision taken from a head flit.
  function automatic route_e route_of(input logic hit, input logic bcast,
                                      input logic last_tap);
    route_e r;
    if (bcast)         r = last_tap ? RT_LOCAL : RT_BOTH;
    else if (hit)      r = RT_LOCAL;
    else if (last_tap) r = RT_DROP;
    else               r = RT_PASS;
    return r;
  endfunction

  function automatic logic route_local(input route_e r);
    return (r == RT_LOCAL) || (r == RT_BOTH);
  endfunction

  function automatic logic route_pass(input route_e r);
    return (r == RT_PASS) || (r == RT_BOTH);
  endfunction

endpackage

// File: rtl/mdx_head_decode.sv
module mdx_head_decode
  import mdx_tap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter bit LAST_TAP = 1'b0
) (
  input  logic [DATA_W-1:0] flit_data,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic              addr_hit,
  output logic              bcast_flag,
  output route_e            head_route
);

  localparam int BCAST_POS = ADDR_W;

  logic [ADDR_W-1:0] dest_field;

  always_comb begin
    dest_field = flit_data[ADDR_W-1:0];
    bcast_flag = flit_data[BCAST_POS];
    addr_hit   = (dest_field == tap_addr);
    head_route = route_of(addr_hit, bcast_flag, LAST_TAP);
  end

endmodule

// File: rtl/mdx_steer_state.sv
module mdx_steer_state
  import mdx_tap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flit_vld,
  input  logic   flit_head,
  input  logic   flit_tail,
  input  route_e head_route,
  output route_e cur_route,
  output logic   pkt_open
);

  route_e held_route;

  // Choice applied to the flit in this cycle.
  always_comb begin
    if (!flit_vld)      cur_route = RT_NONE;
    else if (flit_head) cur_route = head_route;
    else                cur_route = held_route;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_route <= RT_NONE;
    end else if (flit_vld) begin
      if (flit_tail)      held_route <= RT_NONE;
      else if (flit_head) held_route <= head_route;
    end
  end

  assign pkt_open = (held_route != RT_NONE);

endmodule

// File: rtl/mdx_out_stage.sv
module mdx_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] in_word,
  output logic         out_vld,
  output logic [W-1:0] out_word
);

  // The word register loads only on a taken flit, so an idle output keeps
  // its last value and the wires beyond it do not toggle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= take;
      if (take) out_word <= in_word;
    end
  end

endmodule

// File: rtl/mdx_drop_tap.sv
module mdx_drop_tap
  import mdx_tap_pkg::*;
#(
  parameter int NODE_CNT = 8,
  parameter int DATA_W   = 16,
  parameter bit LAST_TAP = 1'b0,
  localparam int ADDR_W  = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tap_addr,
  input  logic              up_vld,
  input  logic              up_head,
  input  logic              up_tail,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_vld,
  output logic              dn_head,
  output logic              dn_tail,
  output logic [DATA_W-1:0] dn_data,
  output logic              loc_vld,
  output logic              loc_head,
  output logic              loc_tail,
  output logic [DATA_W-1:0] loc_data,
  output logic              misroute_err
);

  localparam int WORD_W = DATA_W + 2;
  localparam int N_OUT  = 2;  // 0: downstream, 1: local

  // Named internal events, also watched by the checker.
  logic   head_hit;
  logic   head_bcast;
  route_e head_route;
  route_e cur_route;
  logic   pkt_open;
  logic   take_pass;
  logic   take_local;
  logic   take_drop;

  mdx_head_decode #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .LAST_TAP(LAST_TAP)
  ) u_decode (
    .flit_data (up_data),
    .tap_addr  (tap_addr),
    .addr_hit  (head_hit),
    .bcast_flag(head_bcast),
    .head_route(head_route)
  );

  mdx_steer_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .flit_vld  (up_vld),
    .flit_head (up_head),
    .flit_tail (up_tail),
    .head_route(head_route),
    .cur_route (cur_route),
    .pkt_open  (pkt_open)
  );

  assign take_pass  = route_pass(cur_route);
  assign take_local = route_local(cur_route);
  assign take_drop  = up_vld && up_head && (cur_route == RT_DROP);

  logic [WORD_W-1:0] in_word;
  logic [N_OUT-1:0]  take_vec;
  logic [N_OUT-1:0]  vld_vec;
  logic [WORD_W-1:0] word_vec [N_OUT];

  assign in_word  = {up_head, up_tail, up_data};
  assign take_vec = {take_local, take_pass};

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    mdx_out_stage #(.W(WORD_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take_vec[g]),
      .in_word (in_word),
      .out_vld (vld_vec[g]),
      .out_word(word_vec[g])
    );
  end

  assign dn_vld                     = vld_vec[0];
  assign {dn_head, dn_tail, dn_data} = word_vec[0];
  assign loc_vld                    = vld_vec[1];
  assign {loc_head, loc_tail, loc_data} = word_vec[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misroute_err <= 1'b0;
    else        misroute_err <= take_drop;
  end

endmodule

// File: rtl/mdx_drop_tap_chk.sv
module mdx_drop_tap_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter bit LAST_TAP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] tap_addr,
  input logic              up_vld,
  input logic              up_head,
  input logic              up_tail,
  input logic [DATA_W-1:0] up_data,
  input logic              dn_vld,
  input logic              dn_head,
  input logic              dn_tail,
  input logic [DATA_W-1:0] dn_data,
  input logic              loc_vld,
  input logic              loc_head,
  input logic              loc_tail,
  input logic [DATA_W-1:0] loc_data,
  input logic              misroute_err,
  input logic              pkt_open
);

  logic head_in, hit_in, bc_in;
  assign head_in = up_vld && up_head;
  assign hit_in  = (up_data[ADDR_W-1:0] == tap_addr);
  assign bc_in   = up_data[ADDR_W];

  p_match_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    head_in && !bc_in && hit_in |=> loc_vld && !dn_vld && loc_head
                                    && loc_data == $past(up_data));

  p_miss_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    head_in && !bc_in && !hit_in && !LAST_TAP |=> dn_vld && !loc_vld
                                    && dn_data == $past(up_data));

  p_bcast_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    head_in && bc_in |=> loc_vld && (dn_vld == !LAST_TAP));

  p_tail_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_vld && up_tail |=> !pkt_open);

  p_dn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_vld |-> $stable(dn_data) && $stable(dn_head) && $stable(dn_tail));

  p_loc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_vld |-> $stable(loc_data) && $stable(loc_head) && $stable(loc_tail));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misroute_err |-> !dn_vld && !loc_vld && $past(head_in));

  p_bubble_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_vld |=> !dn_vld && !loc_vld && !misroute_err);

endmodule

bind mdx_drop_tap mdx_drop_tap_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .LAST_TAP(LAST_TAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tap_addr    (tap_addr),
  .up_vld      (up_vld),
  .up_head     (up_head),
  .up_tail     (up_tail),
  .up_data     (up_data),
  .dn_vld      (dn_vld),
  .dn_head     (dn_head),
  .dn_tail     (dn_tail),
  .dn_data     (dn_data),
  .loc_vld     (loc_vld),
  .loc_head    (loc_head),
  .loc_tail    (loc_tail),
  .loc_data    (loc_data),
  .misroute_err(misroute_err),
  .pkt_open    (pkt_open)
);

// File: tb/mdx_drop_tap_bench.sv
module mdx_drop_tap_bench;

  localparam int CLK_PERIOD = 10;
  localparam int K          = 8;
  localparam int DW         = 16;
  localparam int AW         = 3;
  localparam int WDOG       = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_vld = 1'b0, up_head = 1'b0, up_tail = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic [AW-1:0] addr_mid  = 3'd5;
  logic [AW-1:0] addr_last = 3'd7;

  logic          o_dv [2];
  logic          o_dh [2];
  logic          o_dt [2];
  logic [DW-1:0] o_dd [2];
  logic          o_lv [2];
  logic          o_lh [2];
  logic          o_lt [2];
  logic [DW-1:0] o_ld [2];
  logic          o_er [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdx_drop_tap #(.NODE_CNT(K), .DATA_W(DW), .LAST_TAP(1'b0)) u_mdx_drop_tap (
    .clk(clk), .rst_n(rst_n), .tap_addr(addr_mid),
    .up_vld(up_vld), .up_head(up_head), .up_tail(up_tail), .up_data(up_data),
    .dn_vld(o_dv[0]), .dn_head(o_dh[0]), .dn_tail(o_dt[0]), .dn_data(o_dd[0]),
    .loc_vld(o_lv[0]), .loc_head(o_lh[0]), .loc_tail(o_lt[0]), .loc_data(o_ld[0]),
    .misroute_err(o_er[0]));

  mdx_drop_tap #(.NODE_CNT(K), .DATA_W(DW), .LAST_TAP(1'b1)) u_mdx_drop_tap_last (
    .clk(clk), .rst_n(rst_n), .tap_addr(addr_last),
    .up_vld(up_vld), .up_head(up_head), .up_tail(up_tail), .up_data(up_data),
    .dn_vld(o_dv[1]), .dn_head(o_dh[1]), .dn_tail(o_dt[1]), .dn_data(o_dd[1]),
    .loc_vld(o_lv[1]), .loc_head(o_lh[1]), .loc_tail(o_lt[1]), .loc_data(o_ld[1]),
    .misroute_err(o_er[1]));

  // Reference model: 0 idle, 1 keep, 2 repeat, 3 keep and repeat, 4 discard with error.
  int            mode [2];
  logic          e_dv [2], e_lv [2], e_er [2];
  logic [DW+1:0] e_dw [2], e_lw [2];

  int n_chk = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  function automatic int pick(int t, logic [DW-1:0] d);
    int dest;
    bit bc;
    dest = d % K;
    bc   = d[AW];
    if (bc) return (t == 1) ? 1 : 3;
    if (dest == ((t == 0) ? 5 : 7)) return 1;
    return (t == 1) ? 4 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int t = 0; t < 2; t++) begin
      if (!rst_n) begin
        mode[t] = 0; e_dv[t] = 0; e_lv[t] = 0; e_er[t] = 0;
        e_dw[t] = '0; e_lw[t] = '0;
      end else begin
        int r;
        r = 0;
        if (up_vld) r = up_head ? pick(t, up_data) : mode[t];
        e_dv[t] = (r == 2 || r == 3);
        e_lv[t] = (r == 1 || r == 3);
        e_er[t] = up_vld && up_head && (r == 4);
        if (e_dv[t]) e_dw[t] = {up_head, up_tail, up_data};
        if (e_lv[t]) e_lw[t] = {up_head, up_tail, up_data};
        if (up_vld) begin
          if (up_tail)      mode[t] = 0;
          else if (up_head) mode[t] = r;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    for (int t = 0; t < 2; t++) begin
      logic [2*DW+6:0] act, exp;
      act = {o_dv[t], o_dh[t], o_dt[t], o_dd[t], o_lv[t], o_lh[t], o_lt[t], o_ld[t], o_er[t]};
      exp = {e_dv[t], e_dw[t], e_lv[t], e_lw[t], e_er[t]};
      n_chk++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s tap%0d cycle %0d: actual %h expected %h", req, t, cyc, act, exp);
      end
    end
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
      $finish;
    end
  end

  task automatic flit(input logic v, input logic h, input logic tl, input logic [DW-1:0] d);
    @(negedge clk);
    up_vld = v; up_head = h; up_tail = tl; up_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) flit(1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R2: three-flit packet for node 5 (dest bits [2:0], broadcast bit 3).
    req = "R2";
    flit(1, 1, 0, 16'hA105); flit(1, 0, 0, 16'h1234); flit(1, 0, 1, 16'h5678); idle(2);
    // R3: packet for node 2, repeated at the middle tap, misrouted at the last tap.
    req = "R3";
    flit(1, 1, 0, 16'hB202); flit(1, 0, 0, 16'hCAFE); flit(1, 0, 1, 16'hBEEF); idle(2);
    // R4: body payloads that mimic addresses and the broadcast bit.
    req = "R4";
    flit(1, 1, 0, 16'h0C01); flit(1, 0, 0, 16'h0005); flit(1, 0, 0, 16'h000F);
    flit(1, 0, 1, 16'h0007); idle(1);
    flit(1, 1, 0, 16'h0D05); flit(1, 0, 0, 16'h0002); flit(1, 0, 1, 16'h0008); idle(2);
    // R5: broadcast packet.
    req = "R5";
    flit(1, 1, 0, 16'hE00B); flit(1, 0, 1, 16'h4321); idle(2);
    // R6: back-to-back single-flit packets, then a stray body flit.
    req = "R6";
    flit(1, 1, 1, 16'h1105); flit(1, 1, 1, 16'h2203); flit(1, 1, 1, 16'h3307);
    flit(1, 1, 1, 16'h440C); flit(1, 0, 0, 16'h5505); flit(1, 0, 1, 16'h6606); idle(2);
    // R7: idle gaps after both outputs carried data; hold is compared every cycle.
    req = "R7";
    flit(1, 1, 1, 16'h7701); idle(4); flit(1, 1, 1, 16'h8805); idle(4);
    // R8: last tap sees a packet for node 3.
    req = "R8";
    flit(1, 1, 0, 16'h9903); flit(1, 0, 0, 16'h0007); flit(1, 0, 1, 16'h000F); idle(2);
    // R9: bubbles inside packets.
    req = "R9";
    flit(1, 1, 0, 16'hAA05); idle(2); flit(1, 0, 0, 16'h0102); idle(1); flit(1, 0, 1, 16'h0203);
    flit(1, 1, 0, 16'hAB06); idle(3); flit(1, 0, 1, 16'h0304);
    flit(1, 1, 0, 16'hAC07); idle(1); flit(1, 0, 1, 16'h0405); idle(3);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule